// File: doc/BRIEF.md
# Programmable Per-Line Edge Detector Bank

The block watches a wide bus of input lines (256 by default) and flags, on every clock, each line on which a transition of the programmed kind has just occurred. Each line has a two-bit mode that selects rising, falling, both-edge or no detection. A per-line mask bit silences a line regardless of its mode. Results leave the block as a registered hit vector plus a registered any-hit flag.

Modes and masks live in 32-bit registers behind a small synchronous register port (address, write enable, write data, registered read data). Full-word writes program sixteen lines' modes at once. A dedicated line-program address updates one line's mode without touching its neighbours, so independent agents need no read-modify-write. The address space always reserves room for sixteen control registers. A build can implement fewer of them, and the missing ones absorb writes harmlessly.

Top module: `edge_sense_bank`

## Requirements
- R1: With mode code 00 a line reports a hit when its previous sampled value was 0 and its current sampled value is 1.
- R2: With mode code 01 a line reports a hit when its previous sampled value was 1 and its current sampled value is 0.
- R3: With mode code 10 a line reports a hit on either a 0-to-1 or a 1-to-0 change.
- R4: Mode code 11 never produces a hit.
- R5: Mask register k, at address 16+k, holds the mask of line 32k+b in bit b. A set mask bit forces that line's hit to 0 in every mode.
- R6: The mode of line n sits in control register n/16 (addresses 0 to 15), at bits [2*(n%16)+1 : 2*(n%16)]. Full-word writes are read back unchanged.
- R7: After reset every register reads 0, and no hit is reported in the first cycle out of reset, whatever the inputs. A hit appears on `hit` one clock after the edge that samples the second value of the transition.
- R8: `any_hit` equals the OR of `hit`, registered in the same cycle.
- R9: A write to address 24 sets the mode of line wdata[7:0] to wdata[17:16] and leaves every other mode field unchanged. Address 24 reads as 0.
- R10: Control addresses at or above IMPL_CTRL ignore writes and read 0, and the lines they would control never hit. Unused addresses 25 to 31 read 0.
- R11: Read data is registered: it returns the contents of the addressed register one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register word address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| line_in | input | 256 | Monitored input lines |
| hit | output | 256 | Per-line detection result |
| any_hit | output | 1 | OR of all hits |

## Verification
The main function is swept over every pair of consecutive values (0-0, 0-1, 1-0, 1-1) on lines at register and mask-word boundaries, in all four modes, with the mask both clear and set. The steady pairs separate real edge detection from level detection. The two changing pairs separate the rising, falling and toggle codes, and the reserved code is shown to stay silent on both. The bench also drives all lines high through reset to expose any false edge, and uses the line-program address on two lines that share one register to show that neighbouring fields survive. A build with only twelve control registers shows that writes to the missing registers, and the lines behind them, change nothing.

// File: rtl/edge_sense_bank.sv
module edge_sense_bank #(
  parameter int LINES     = 256,
  parameter int IMPL_CTRL = 16,
  parameter int ADDR_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [LINES-1:0]  line_in,
  output logic [LINES-1:0]  hit,
  output logic              any_hit
);
  localparam int CTRL_SLOTS = LINES / 16;
  localparam int MASK_REGS  = LINES / 32;
  localparam int MASK_BASE  = CTRL_SLOTS;
  localparam int PROG_ADDR  = MASK_BASE + MASK_REGS;
  localparam int LINE_W     = $clog2(LINES);
  localparam int MODE_LSB   = 16;

  logic [31:0]          ctrl_word [CTRL_SLOTS];
  logic [31:0]          mask_q    [MASK_REGS];
  logic [2*LINES-1:0]   mode_flat;
  logic [LINES-1:0]     mask_flat, impl_flat, rsvd_flat;
  logic [LINES-1:0]     prev_q, det, edge_r, edge_f;
  logic                 primed_q;
  logic                 prog_we;

  assign prog_we = reg_we && (reg_addr == ADDR_W'(PROG_ADDR));

  for (genvar g = 0; g < CTRL_SLOTS; g++) begin : g_ctrl
    if (g < IMPL_CTRL) begin : g_impl
      logic [31:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else if (reg_we && reg_addr == ADDR_W'(g)) word_q <= reg_wdata;
        else if (prog_we && reg_wdata[LINE_W-1:4] == (LINE_W-4)'(g)) begin
          for (int f = 0; f < 16; f++)
            if (reg_wdata[3:0] == 4'(f)) word_q[2*f +: 2] <= reg_wdata[MODE_LSB +: 2];
        end
      end
      assign ctrl_word[g]          = word_q;
      assign impl_flat[g*16 +: 16] = '1;
    end else begin : g_none
      assign ctrl_word[g]          = '0;
      assign impl_flat[g*16 +: 16] = '0;
    end
    assign mode_flat[g*32 +: 32] = ctrl_word[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < MASK_REGS; k++) mask_q[k] <= '0;
    end else if (reg_we) begin
      for (int k = 0; k < MASK_REGS; k++)
        if (reg_addr == ADDR_W'(MASK_BASE + k)) mask_q[k] <= reg_wdata;
    end
  end

  for (genvar k = 0; k < MASK_REGS; k++) begin : g_mask
    assign mask_flat[k*32 +: 32] = mask_q[k];
  end

  assign edge_r = ~prev_q & line_in;
  assign edge_f = prev_q & ~line_in;

  for (genvar n = 0; n < LINES; n++) begin : g_line
    logic [1:0] md;
    assign md           = mode_flat[2*n +: 2];
    assign rsvd_flat[n] = (md == 2'b11);
    assign det[n] = impl_flat[n] & ~mask_flat[n] &
                    (((md == 2'b00) & edge_r[n]) |
                     ((md == 2'b01) & edge_f[n]) |
                     ((md == 2'b10) & (edge_r[n] | edge_f[n])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      hit      <= '0;
      any_hit  <= 1'b0;
    end else begin
      prev_q   <= line_in;
      primed_q <= 1'b1;
      hit      <= primed_q ? det : '0;
      any_hit  <= primed_q && (|det);
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < CTRL_SLOTS; i++)
      if (reg_addr == ADDR_W'(i)) rd_mux = ctrl_word[i];
    for (int k = 0; k < MASK_REGS; k++)
      if (reg_addr == ADDR_W'(MASK_BASE + k)) rd_mux = mask_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_mux;
  end

  assert_edge_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & ~($past(line_in) ^ $past(prev_q))) == '0);
  assert_reserved_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & $past(rsvd_flat)) == '0);
  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & $past(mask_flat)) == '0);
  assert_first_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(primed_q) |-> hit == '0);
  assert_any_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit == (|hit));
endmodule

// File: tb/edge_sense_bank_bench.sv
module edge_sense_bank_bench;
  localparam int LINES = 256;
  localparam int IMPL  = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [4:0]        reg_addr = '0;
  logic              reg_we = 1'b0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [LINES-1:0]  line_in = '1;
  logic [LINES-1:0]  hit;
  logic              any_hit;
  int total = 0, fails = 0;
  bit done = 0;

  edge_sense_bank #(.LINES(LINES), .IMPL_CTRL(IMPL), .ADDR_W(5)) u_edge_sense_bank (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_in(line_in),
    .hit(hit), .any_hit(any_hit));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [LINES-1:0] act, input logic [LINES-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_addr = 5'(a); reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); reg_addr = 5'(a);
    @(negedge clk); d = reg_rdata;
  endtask

  function automatic bit expect_hit(int m, int k, int impl, int a, int b);
    if (k != 0 || impl == 0) return 0;
    case (m)
      0: return (a == 0 && b == 1);
      1: return (a == 1 && b == 0);
      2: return (a != b);
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [LINES-1:0] exp;
    int lines_l[7] = '{0, 7, 8, 37, 100, 191, 200};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hit == '0 && !any_hit, "R7 first cycle quiet", hit, '0);
    @(negedge clk);
    chk(hit == '0, "R7 steady high quiet", hit, '0);
    for (int a = 0; a < 32; a++) begin
      rd(a, d);
      chk(d == 32'h0, "R7 reset register value", LINES'(d), '0);
    end
    line_in = '0;
    @(negedge clk); @(negedge clk);

    wr(24, (32'd1 << 16) | 32'd7);
    rd(0, d);
    chk(d == 32'h4000, "R6 line 7 falling", LINES'(d), LINES'(32'h4000));
    wr(24, (32'd2 << 16) | 32'd8);
    rd(0, d);
    chk(d == 32'h24000, "R9 neighbour field kept", LINES'(d), LINES'(32'h24000));
    rd(24, d);
    chk(d == 32'h0, "R9 program address reads 0", LINES'(d), '0);
    wr(3, 32'hA5C3_1E77);
    @(negedge clk); reg_addr = 5'd3;
    @(negedge clk);
    chk(reg_rdata == 32'hA5C3_1E77, "R11 read one cycle later", LINES'(reg_rdata), LINES'(32'hA5C3_1E77));
    wr(3, 32'h0);
    wr(17, 32'h8000_0001);
    rd(17, d);
    chk(d == 32'h8000_0001, "R5 mask readback", LINES'(d), LINES'(32'h8000_0001));
    wr(17, 32'h0);
    wr(13, 32'hFFFF_FFFF);
    rd(13, d);
    chk(d == 32'h0, "R10 unimplemented write ignored", LINES'(d), '0);
    wr(24, (32'd2 << 16) | 32'd200);
    rd(12, d);
    chk(d == 32'h0, "R10 program to unimplemented ignored", LINES'(d), '0);
    rd(27, d);
    chk(d == 32'h0, "R10 unused address reads 0", LINES'(d), '0);
    wr(0, 32'h0);

    foreach (lines_l[i]) begin
      int ln = lines_l[i];
      for (int m = 0; m < 4; m++) begin
        wr(24, (32'(m) << 16) | 32'(ln));
        for (int k = 0; k < 2; k++) begin
          wr(16 + ln / 32, 32'(k) << (ln % 32));
          for (int a = 0; a < 2; a++) begin
            for (int b = 0; b < 2; b++) begin
              string req;
              @(negedge clk); line_in[ln] = 1'(a);
              @(negedge clk); line_in[ln] = 1'(b);
              @(negedge clk);
              exp = '0;
              exp[ln] = expect_hit(m, k, (ln / 16 < IMPL) ? 1 : 0, a, b);
              if (ln / 16 >= IMPL) req = "R10 unimplemented line";
              else if (k == 1) req = "R5 masked line";
              else if (m == 0) req = "R1 rising";
              else if (m == 1) req = "R2 falling";
              else if (m == 2) req = "R3 toggle";
              else req = "R4 reserved";
              chk(hit == exp, req, hit, exp);
              chk(any_hit == (exp != '0), "R8 any-hit flag", LINES'(any_hit), LINES'(exp != '0));
            end
          end
        end
        wr(16 + ln / 32, 32'h0);
      end
      wr(24, 32'(ln));
      line_in[ln] = 1'b0;
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule